// File: doc/BRIEF.md
# Shared-Bus Arbiter with Split Masking

This block decides which of several bus masters owns a shared AHB-style bus. Each master raises a request line and may also raise a lock line. The arbiter registers a one-hot grant on every clock edge. The ownership index and the locked-transfer flag follow that grant, but only on edges where the bus reports ready. A winner is chosen by fixed priority, where the lowest index wins. A parameter can select a rotating (round-robin) order instead.

Some conditions keep the current owner on the bus:

- a held lock line;
- a fixed-length burst that still has beats left to issue.

When a slave answers with a split response, the master that owns the bus is masked. A masked master cannot win until the slave sets that master's bit on the unmask vector. When nobody eligible is requesting, the bus goes to a default master. If that default master is itself masked, the bus goes to a dummy owner that only issues idle transfers.

Real masters use indices 0 to `NUM_MST-1`, so `NUM_MST` may be at most 15. The dummy owner takes index `DUMMY_ID`, which is 15 by default.

Top module: `bus_arbiter`

## Requirements
- R1: Reset (synchronous, active high) makes the default master `DFLT_MST` the owner: its grant bit is set, `hmaster` equals its index, `hmastlock` is low, and every split mask bit is cleared. A master that was masked before reset can win right after it.
- R2: In the fixed-priority variant, the grant on the edge after the inputs are sampled names the lowest-indexed master that is both requesting and unmasked. At most one grant bit is ever set.
- R3: `hmaster` and `hmastlock` change only on an edge where `hready` is high. On such an edge they take the grant index that was registered before that edge.
- R4: While the granted master holds its lock line and is unmasked, the grant does not move, even if that master drops its request. On the next ready edge `hmastlock` rises. Once the lock line falls, normal arbitration resumes and `hmastlock` falls on the next ready edge.
- R5: A transfer with `htrans` = 2'b10 (first beat) accepted with `hready` high and with a burst code of 2 or 3 (4 beats), 4 or 5 (8 beats), or 6 or 7 (16 beats) holds the grant. The hold lasts until the last beat with `htrans` = 2'b11 is accepted. Beats presented while `hready` is low are not counted.
- R6: Burst code 0 (single) and code 1 (undefined length) give no protection. The grant may move on any cycle, for example to a lower-priority requester once the owner stops requesting.
- R7: If no unmasked master requests and the default master is unmasked, the grant goes to the default master. If the default master is masked, the bus goes to the dummy owner: all grant bits are low, and `hmaster` shows `DUMMY_ID` after the next ready edge.
- R8: A split response (`hresp` = 2'b11) masks the master currently shown on `hmaster`, and the mask takes effect in that same arbitration. A masked master is never granted, even when it is the only requester. The split also cancels any burst hold.
- R9: Setting bit i of `hsplit` clears the mask of master i, and master i is eligible in that same arbitration. If the same cycle also splits master i, the new mask is kept.
- R10: When every master is masked, the dummy owner holds the bus whatever the requests are.
- R11: A retry response (`hresp` = 2'b10) changes no mask and no priority. The retried master keeps the grant if it is still the best requester and otherwise loses it to a better one.
- R12: With `ROUND_ROBIN` = 1, the search starts at the master after the one currently granted and wraps around. Four masters requesting all the time are granted in turn: 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_MST | Bus request, one bit per master |
| lock | input | NUM_MST | Lock request, one bit per master |
| hready | input | 1 | Bus ready; high ends the current transfer |
| htrans | input | 2 | Transfer type of the current address phase |
| hburst | input | 3 | Burst code of the current address phase |
| hresp | input | 2 | Slave response: 00 okay, 01 error, 10 retry, 11 split |
| hsplit | input | 16 | Per-master unmask vector from split-capable slaves |
| grant | output | NUM_MST | One-hot grant; all low when the dummy owner is selected |
| hmaster | output | 4 | Index of the master that owns the address phase |
| hmastlock | output | 1 | Current owner is performing a locked sequence |

## Verification
The grant is due one rising edge after the request, lock, response and unmask inputs are applied. `hmaster` and `hmastlock` arrive one ready edge later, carrying the grant that was registered before that edge. The bench applies each input set on a falling edge and compares all three outputs on the next falling edge. Each table row therefore expects `hmaster` to equal the grant of the row before it, unless `hready` was low. Burst rows count accepted beats by hand: the grant moves on the edge that takes in the last beat, not on the following one.

// File: rtl/barb_pkg.sv
package barb_pkg;

    localparam int MID_W  = 4;
    localparam int BEAT_W = 5;

    typedef logic [MID_W-1:0]  mid_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } resp_e;

    // Result of one arbitration search.
    typedef struct packed {
        logic valid;
        mid_t id;
    } pick_t;

    // Number of beats a burst code implies; 1 for single and open-ended bursts.
    function automatic beat_t burst_beats(input logic [2:0] code);
        case (code)
            3'd2, 3'd3: return beat_t'(4);
            3'd4, 3'd5: return beat_t'(8);
            3'd6, 3'd7: return beat_t'(16);
            default:    return beat_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/barb_beat_track.sv
module barb_beat_track
    import barb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hready,
    input  logic [1:0] htrans,
    input  logic [2:0] hburst,
    input  logic       abort,
    output logic       busy
);

    beat_t left_q;
    beat_t left_nxt;

    // Beats still to be issued after the one accepted this cycle.
    always_comb begin
        left_nxt = left_q;
        if (abort) begin
            left_nxt = '0;
        end else if (hready) begin
            if (htrans == TR_NONSEQ) begin
                left_nxt = burst_beats(hburst) - beat_t'(1);
            end else if (htrans == TR_SEQ && left_q != '0) begin
                left_nxt = left_q - beat_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else begin
            left_q <= left_nxt;
        end
    end

    assign busy = (left_nxt != '0);

    AST_BEAT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!hready && !abort) |=> (left_q == $past(left_q))) else $error("beat count moved without ready"); // R5

    AST_BEAT_ABORT: assert property (@(posedge clk) disable iff (rst)
        abort |=> (left_q == '0)) else $error("split did not cancel burst"); // R8

endmodule

// File: rtl/barb_split_mask.sv
module barb_split_mask #(
    parameter int NUM_MST = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               split_hit,
    input  logic [NUM_MST-1:0] owner_oh,
    input  logic [NUM_MST-1:0] unmask,
    output logic [NUM_MST-1:0] mask_q,
    output logic [NUM_MST-1:0] mask_nxt
);

    logic [NUM_MST-1:0] set_vec;

    assign set_vec  = split_hit ? owner_oh : '0;
    // A fresh split outranks a same-cycle unmask of the same master.
    assign mask_nxt = (mask_q & ~unmask) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_nxt;
        end
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        split_hit |=> ((mask_q & $past(owner_oh)) == $past(owner_oh))) else $error("split owner not masked"); // R8

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !split_hit |=> ((mask_q & $past(unmask)) == '0)) else $error("unmask ignored"); // R9

endmodule

// File: rtl/barb_pick.sv
module barb_pick
    import barb_pkg::*;
#(
    parameter int NUM_MST     = 4,
    parameter bit ROUND_ROBIN = 1'b0
) (
    input  logic [NUM_MST-1:0] elig,
    input  mid_t               start,
    output pick_t              res
);

    generate
        if (ROUND_ROBIN) begin : g_rotate
            always_comb begin
                res = '0;
                // Walk backwards so the nearest candidate after start is written last.
                for (int k = NUM_MST - 1; k >= 0; k--) begin
                    int idx;
                    idx = (int'(start) + k) % NUM_MST;
                    if (elig[idx]) begin
                        res = '{valid: 1'b1, id: mid_t'(idx)};
                    end
                end
            end
        end else begin : g_fixed
            always_comb begin
                res = '0;
                for (int i = NUM_MST - 1; i >= 0; i--) begin
                    if (elig[i]) begin
                        res = '{valid: 1'b1, id: mid_t'(i)};
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import barb_pkg::*;
#(
    parameter int NUM_MST     = 4,
    parameter int DFLT_MST    = 0,
    parameter int DUMMY_ID    = 15,
    parameter bit ROUND_ROBIN = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_MST-1:0] req,
    input  logic [NUM_MST-1:0] lock,
    input  logic               hready,
    input  logic [1:0]         htrans,
    input  logic [2:0]         hburst,
    input  logic [1:0]         hresp,
    input  logic [15:0]        hsplit,
    output logic [NUM_MST-1:0] grant,
    output logic [3:0]         hmaster,
    output logic               hmastlock
);

    localparam mid_t LAST_ID   = mid_t'(NUM_MST - 1);
    localparam mid_t DFLT_MID  = mid_t'(DFLT_MST);
    localparam mid_t DUMMY_MID = mid_t'(DUMMY_ID);

    function automatic logic [NUM_MST-1:0] id_to_oh(input mid_t id);
        logic [NUM_MST-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_MST; i++) begin
            if (id == mid_t'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

    mid_t gnt_id_q;
    mid_t gnt_nxt;
    mid_t hm_q;
    logic hml_q;

    logic [NUM_MST-1:0] gnt_oh;
    logic [NUM_MST-1:0] hm_oh;
    logic [NUM_MST-1:0] mask_q;
    logic [NUM_MST-1:0] mask_nxt;
    logic [NUM_MST-1:0] elig;
    logic               split_hit;
    logic               burst_busy;
    logic               gnt_ok;
    logic               lock_keep;
    logic               hold;
    mid_t               rr_start;
    pick_t              pick;

    generate
        if (NUM_MST < 16) begin : g_spare_split
            logic unused_hsplit_hi;
            assign unused_hsplit_hi = ^hsplit[15:NUM_MST];
        end
    endgenerate

    assign gnt_oh    = id_to_oh(gnt_id_q);
    assign hm_oh     = id_to_oh(hm_q);
    assign split_hit = (hresp == RSP_SPLIT);

    barb_split_mask #(.NUM_MST(NUM_MST)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .split_hit(split_hit),
        .owner_oh (hm_oh),
        .unmask   (hsplit[NUM_MST-1:0]),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    barb_beat_track u_beats (
        .clk   (clk),
        .rst   (rst),
        .hready(hready),
        .htrans(htrans),
        .hburst(hburst),
        .abort (split_hit),
        .busy  (burst_busy)
    );

    // Holding only applies to a real, still-unmasked grantee.
    assign gnt_ok    = |(gnt_oh & ~mask_nxt);
    assign lock_keep = gnt_ok && |(gnt_oh & lock);
    assign hold      = gnt_ok && (burst_busy || |(gnt_oh & lock));
    assign elig      = req & ~mask_nxt;

    always_comb begin
        if (gnt_id_q >= LAST_ID) begin
            rr_start = '0;
        end else begin
            rr_start = gnt_id_q + mid_t'(1);
        end
    end

    barb_pick #(.NUM_MST(NUM_MST), .ROUND_ROBIN(ROUND_ROBIN)) u_pick (
        .elig (elig),
        .start(rr_start),
        .res  (pick)
    );

    always_comb begin
        if (hold) begin
            gnt_nxt = gnt_id_q;
        end else if (pick.valid) begin
            gnt_nxt = pick.id;
        end else if (mask_nxt[DFLT_MST]) begin
            gnt_nxt = DUMMY_MID;
        end else begin
            gnt_nxt = DFLT_MID;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_id_q <= DFLT_MID;
            hm_q     <= DFLT_MID;
            hml_q    <= 1'b0;
        end else begin
            gnt_id_q <= gnt_nxt;
            if (hready) begin
                hm_q  <= gnt_id_q;
                hml_q <= lock_keep;
            end
        end
    end

    assign grant     = gnt_oh;
    assign hmaster   = hm_q;
    assign hmastlock = hml_q;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("multiple grants"); // R2

    AST_OWNER_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !hready |=> ($stable(hmaster) && $stable(hmastlock))) else $error("owner moved while not ready"); // R3

    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
        lock_keep |=> (gnt_id_q == $past(gnt_id_q))) else $error("locked grant moved"); // R4

    AST_BURST_KEEP: assert property (@(posedge clk) disable iff (rst)
        (burst_busy && gnt_ok) |=> $stable(gnt_id_q)) else $error("burst interrupted"); // R5

    AST_MASK_EXCL: assert property (@(posedge clk) disable iff (rst)
        ((grant & mask_q) == '0)) else $error("masked master granted"); // R8

    AST_ALL_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> (grant == '0 && gnt_id_q == DUMMY_MID)) else $error("all split but not dummy"); // R10

endmodule

// File: tb/bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  req, lock;
    logic        hready;
    logic [1:0]  htrans, hresp;
    logic [2:0]  hburst;
    logic [15:0] hsplit;
    logic [3:0]  gnt_f, gnt_r, hm_f, hm_r;
    logic        hml_f, hml_r;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_arbiter #(.NUM_MST(4), .DFLT_MST(0), .DUMMY_ID(15), .ROUND_ROBIN(1'b0)) dut_i (
        .clk(clk), .rst(rst), .req(req), .lock(lock), .hready(hready),
        .htrans(htrans), .hburst(hburst), .hresp(hresp), .hsplit(hsplit),
        .grant(gnt_f), .hmaster(hm_f), .hmastlock(hml_f));

    bus_arbiter #(.NUM_MST(4), .DFLT_MST(0), .DUMMY_ID(15), .ROUND_ROBIN(1'b1)) dut_rr (
        .clk(clk), .rst(rst), .req(req), .lock(lock), .hready(hready),
        .htrans(htrans), .hburst(hburst), .hresp(hresp), .hsplit(hsplit),
        .grant(gnt_r), .hmaster(hm_r), .hmastlock(hml_r));

    typedef struct packed {
        logic [3:0] rq;
        logic [3:0] lk;
        logic       rdy;
        logic [1:0] tr;
        logic [2:0] bu;
        logic [1:0] rs;
        logic [3:0] sp;
        logic [3:0] eg;
        logic [3:0] ehm;
        logic       el;
    } vec_t;

    localparam int NVEC = 32;
    // req lock rdy trans burst resp split | grant hmaster hmastlock
    localparam logic [28:0] VEC [NVEC] = '{
        {4'b0100,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0100,4'd0, 1'b0},
        {4'b0110,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0010,4'd2, 1'b0},
        {4'b0110,4'b0000,1'b0,2'b00,3'd0,2'b00,4'b0000, 4'b0010,4'd2, 1'b0},
        {4'b0110,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0010,4'd1, 1'b0},
        {4'b0010,4'b0000,1'b1,2'b10,3'd3,2'b00,4'b0000, 4'b0010,4'd1, 1'b0},
        {4'b0011,4'b0000,1'b1,2'b11,3'd3,2'b00,4'b0000, 4'b0010,4'd1, 1'b0},
        {4'b0001,4'b0000,1'b0,2'b11,3'd3,2'b00,4'b0000, 4'b0010,4'd1, 1'b0},
        {4'b0001,4'b0000,1'b1,2'b11,3'd3,2'b00,4'b0000, 4'b0010,4'd1, 1'b0},
        {4'b0001,4'b0000,1'b1,2'b11,3'd3,2'b00,4'b0000, 4'b0001,4'd1, 1'b0},
        {4'b0001,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0001,4'd0, 1'b0},
        {4'b1000,4'b1000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b1000,4'd0, 1'b0},
        {4'b1001,4'b1000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b1000,4'd3, 1'b1},
        {4'b0001,4'b1000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b1000,4'd3, 1'b1},
        {4'b0001,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0001,4'd3, 1'b0},
        {4'b0000,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0001,4'd0, 1'b0},
        {4'b0100,4'b0000,1'b1,2'b10,3'd1,2'b00,4'b0000, 4'b0100,4'd0, 1'b0},
        {4'b0100,4'b0000,1'b1,2'b11,3'd1,2'b00,4'b0000, 4'b0100,4'd2, 1'b0},
        {4'b0010,4'b0000,1'b1,2'b11,3'd1,2'b00,4'b0000, 4'b0010,4'd2, 1'b0},
        {4'b0010,4'b0000,1'b1,2'b00,3'd0,2'b11,4'b0000, 4'b0010,4'd1, 1'b0},
        {4'b0100,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0001,4'd1, 1'b0},
        {4'b0100,4'b0000,1'b1,2'b00,3'd0,2'b11,4'b0000, 4'b0001,4'd0, 1'b0},
        {4'b0000,4'b0000,1'b1,2'b00,3'd0,2'b11,4'b0000, 4'b0000,4'd0, 1'b0},
        {4'b1000,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b1000,4'd15,1'b0},
        {4'b1000,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b1000,4'd3, 1'b0},
        {4'b0000,4'b0000,1'b1,2'b00,3'd0,2'b11,4'b0000, 4'b0000,4'd3, 1'b0},
        {4'b1111,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0000,4'd15,1'b0},
        {4'b1111,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0100, 4'b0100,4'd15,1'b0},
        {4'b1111,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0011, 4'b0001,4'd2, 1'b0},
        {4'b0001,4'b0000,1'b1,2'b00,3'd0,2'b10,4'b0000, 4'b0001,4'd0, 1'b0},
        {4'b0101,4'b0000,1'b1,2'b00,3'd0,2'b10,4'b1000, 4'b0001,4'd0, 1'b0},
        {4'b0100,4'b0000,1'b1,2'b00,3'd0,2'b00,4'b0000, 4'b0100,4'd0, 1'b0},
        {4'b0110,4'b0000,1'b1,2'b00,3'd0,2'b10,4'b0000, 4'b0010,4'd2, 1'b0}
    };

    localparam logic [3:0] RR_EXP [4] = '{4'b0010, 4'b0100, 4'b1000, 4'b0001};

    function automatic string row_tag(input int i);
        if (i < 2)       return "R2";
        else if (i < 4)  return "R3";
        else if (i < 10) return "R5";
        else if (i < 15) return "R4";
        else if (i < 18) return "R6";
        else if (i == 21) return "R7";
        else if (i < 25) return "R8";
        else if (i == 25) return "R10";
        else if (i < 28) return "R9";
        else             return "R11";
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic idle_inputs();
        req = '0; lock = '0; hready = 1'b1; htrans = 2'b00;
        hburst = 3'd0; hresp = 2'b00; hsplit = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of both variants
        chk("R1", "grant", gnt_f, 4'b0001);
        chk("R1", "hmaster", hm_f, 0);
        chk("R1", "hmastlock", hml_f, 0);
        chk("R1", "rr grant", gnt_r, 4'b0001);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = vec_t'(VEC[i]);
            req = v.rq; lock = v.lk; hready = v.rdy; htrans = v.tr;
            hburst = v.bu; hresp = v.rs; hsplit = {12'b0, v.sp};
            @(negedge clk);
            chk(row_tag(i), $sformatf("row %0d grant", i), gnt_f, v.eg);
            chk(row_tag(i), $sformatf("row %0d hmaster", i), hm_f, v.ehm);
            chk(row_tag(i), $sformatf("row %0d hmastlock", i), hml_f, v.el);
        end

        // R12: rotating order with every master requesting
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R12", $sformatf("turn %0d", k), gnt_r, RR_EXP[k]);
            chk("R2", $sformatf("fixed turn %0d", k), gnt_f, 4'b0001);
        end
        req = 4'b1001;
        @(negedge clk);
        chk("R12", "skip to 3", gnt_r, 4'b1000);
        @(negedge clk);
        chk("R12", "wrap to 0", gnt_r, 4'b0001);

        // R8 then R1: mask a master, then reset must clear the mask
        req = 4'b0010;
        @(negedge clk);
        @(negedge clk);
        chk("R3", "owner before split", hm_f, 1);
        hresp = 2'b11;
        @(negedge clk);
        chk("R8", "split owner loses grant", gnt_f, 4'b0001);
        hresp = 2'b00;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "mask cleared by reset", gnt_f, 4'b0010);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run stalled, got 0 expected 1");
            summary();
            $finish;
        end
    end

endmodule